// File: doc/BRIEF.md
# Memory-Mapped One-Shot Event Timer

This peripheral sits on a simple processor register bus and offers two counters. A free-running timestamp counts up by one on every bus clock and wraps. An event counter counts down once per prescaled tick. The default prescale turns a 100 MHz bus clock into a 1 MHz tick. Software loads the event counter, then sets the run bit in the control byte. When the countdown expires, the block sets a sticky expiry flag, stops itself and raises a level interrupt.

The run bit and the expiry flag share one control byte. The expiry flag is cleared by writing one to it. Software normally acknowledges an expiry by writing the control byte with only the flag bit set. That single write clears the flag and also leaves the timer stopped. Two further control bits, for a repeating mode and an auto-load mode, are stored and read back but do nothing.

Top module: `evt_timer`

## Requirements
- R1: While reset is held, the count, timestamp and control registers read as zero and `irq` is low.
- R2: The timestamp at offset 0x08 increases by exactly one per clock, modulo 2^32. Writes to it are ignored.
- R3: The count register at offset 0x00 takes writes per byte lane: `bus_be[i]` updates bits 8i+7..8i. A read returns the live remaining count.
- R4: Control byte layout at offset 0x14: bit 0 is run, bit 1 is repeat mode, bit 2 is auto-load, bit 7 is the expiry flag, and the other bits read 0. Setting run starts the countdown. The count first drops by one PRESCALE clocks after the write edge and then drops once every PRESCALE clocks. A loaded 0xFFFFFFFF is accepted.
- R5: With N >= 1 loaded, the expiry flag sets exactly N*PRESCALE clocks after the edge that set run. At that edge the run bit clears and the count stays at zero.
- R6: `irq` is high exactly while the expiry flag is set.
- R7: A control write with bit 7 set clears the expiry flag. A control write with bit 7 clear leaves the flag unchanged.
- R8: A control write with bit 0 clear stops the countdown, and the count then holds its value.
- R9: If an expiry and a flag-clearing control write fall on the same edge, the flag stays set.
- R10: The repeat and auto-load bits read back as written and do not change one-shot behaviour.
- R11: A write to offset 0x14 without `bus_be[0]` leaves the control byte unchanged. Unmapped offsets read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access strobe for this peripheral |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_be | input | DW/8 | Byte-lane write enables |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, combinational from `bus_addr` while `bus_sel` is high |
| irq | output | 1 | Level interrupt, high while the expiry flag is set |

## Verification
The properties assume that a write is one cycle with `bus_sel` and `bus_wr` high and a word-aligned `bus_addr`. They also assume that reset is held for at least two clocks, so that the counters have a defined previous value. The stimulus drives every access for exactly one clock from the falling edge, always on aligned offsets, and keeps reset low for three clocks at start-up. The step and hold properties exempt any cycle in which the count register was written, so the bench is free to reload the count while the timer runs or while it is stopped.

// File: rtl/evt_timer_pkg.sv
// Shared offsets, control bit positions and the control register type for the
// event timer. Assumes a 5-bit byte address and word-aligned registers.
package evt_timer_pkg;
    localparam int unsigned AW = 5;
    localparam logic [AW-1:0] OFS_COUNT = 5'h00;
    localparam logic [AW-1:0] OFS_STAMP = 5'h08;
    localparam logic [AW-1:0] OFS_CTRL  = 5'h14;

    localparam int unsigned BIT_RUN = 0;
    localparam int unsigned BIT_REP = 1;
    localparam int unsigned BIT_ALD = 2;
    localparam int unsigned BIT_EXP = 7;

    typedef struct packed {
        logic expd;   // sticky expiry flag
        logic ald;    // auto-load mode bit, stored only
        logic rep;    // repeat mode bit, stored only
        logic run;    // countdown enable
    } ctrl_t;
endpackage

// File: rtl/evt_tick_gen.sv
// Prescaler: gives a one-cycle tick every PRESCALE clocks while run is high.
// It is held at phase zero while stopped, so the first tick comes exactly
// PRESCALE clocks after run rises.
module evt_tick_gen #(
    parameter int unsigned PRESCALE = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int unsigned PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

    logic [PW-1:0] phase_q;

    // Phase counter: wraps at LAST and is reset while the timer is stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            phase_q <= '0;
        end else if (phase_q == LAST) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    // Tick decode: the last phase of each prescale window.
    assign tick = run && (phase_q == LAST);
endmodule

// File: rtl/evt_stamp_ctr.sv
// Free-running up-counter used as the timestamp. Counts every clock and wraps.
module evt_stamp_ctr #(
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [DW-1:0] stamp
);
    logic [DW-1:0] stamp_q;

    // Advance by one on every clock after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stamp_q <= '0;
        end else begin
            stamp_q <= stamp_q + 1'b1;
        end
    end

    assign stamp = stamp_q;
endmodule

// File: rtl/evt_countdown.sv
// Event countdown and control byte. Decrements on each tick while running.
// On a tick with the count at 0 or 1 it expires: the count lands on zero, the
// run bit clears and the sticky flag sets. An expiry beats a write-one-to-clear
// on the same edge. Bus writes to run and the mode bits beat the self-stop.
module evt_countdown
    import evt_timer_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [DW/8-1:0]  cnt_we,
    input  logic             ctl_we,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    count,
    output ctrl_t            ctrl
);
    localparam int unsigned NB = DW / 8;

    logic [DW-1:0] count_q, count_dec, count_nxt;
    ctrl_t         ctrl_q, ctrl_nxt;
    logic          expire;

    // Expiry decode: a tick while running with at most one count left.
    assign expire = ctrl_q.run && tick && (count_q <= DW'(1));

    // Countdown step: one less on each running tick, floored at zero.
    always_comb begin
        count_dec = count_q;
        if (ctrl_q.run && tick) begin
            count_dec = (count_q == '0) ? '0 : count_q - 1'b1;
        end
    end

    // Byte-lane merge: a written lane replaces the decremented value.
    for (genvar g = 0; g < NB; g++) begin : g_lane
        assign count_nxt[8*g +: 8] = cnt_we[g] ? wdata[8*g +: 8] : count_dec[8*g +: 8];
    end

    // Control next state: self-stop, bus write, then flag set and clear.
    always_comb begin
        ctrl_nxt = ctrl_q;
        if (expire) begin
            ctrl_nxt.run = 1'b0;
        end
        if (ctl_we) begin
            ctrl_nxt.run = wdata[BIT_RUN];
            ctrl_nxt.rep = wdata[BIT_REP];
            ctrl_nxt.ald = wdata[BIT_ALD];
            if (wdata[BIT_EXP]) begin
                ctrl_nxt.expd = 1'b0;
            end
        end
        if (expire) begin
            ctrl_nxt.expd = 1'b1;
        end
    end

    // State registers for the count and the control byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            ctrl_q  <= '0;
        end else begin
            count_q <= count_nxt;
            ctrl_q  <= ctrl_nxt;
        end
    end

    assign count = count_q;
    assign ctrl  = ctrl_q;
endmodule

// File: rtl/evt_reg_dec.sv
// Register decode: turns a bus access into per-register write strobes and
// selects the read data. Assumes word-aligned offsets and single-cycle accesses.
module evt_reg_dec
    import evt_timer_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic [AW-1:0]    bus_addr,
    input  logic [DW/8-1:0]  bus_be,
    input  logic [DW-1:0]    count,
    input  logic [DW-1:0]    stamp,
    input  ctrl_t            ctrl,
    output logic [DW/8-1:0]  cnt_we,
    output logic             ctl_we,
    output logic [DW-1:0]    rdata
);
    logic wr_acc;

    // Write strobes: count takes every lane, control takes lane 0 only.
    assign wr_acc = bus_sel && bus_wr;
    assign cnt_we = (wr_acc && bus_addr == OFS_COUNT) ? bus_be : '0;
    assign ctl_we = wr_acc && (bus_addr == OFS_CTRL) && bus_be[0];

    // Read mux: the selected register, zero for unmapped offsets.
    always_comb begin
        rdata = '0;
        if (bus_sel) begin
            case (bus_addr)
                OFS_COUNT: rdata = count;
                OFS_STAMP: rdata = stamp;
                OFS_CTRL:  rdata = DW'({ctrl.expd, 4'b0000, ctrl.ald, ctrl.rep, ctrl.run});
                default:   rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/evt_timer.sv
// Top of the event timer: bus decode, prescaler, timestamp and countdown.
// Assumes a synchronous active-low reset and single-cycle bus accesses.
module evt_timer
    import evt_timer_pkg::*;
#(
    parameter int unsigned DW       = 32,
    parameter int unsigned PRESCALE = 100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic [4:0]       bus_addr,
    input  logic [DW/8-1:0]  bus_be,
    input  logic [DW-1:0]    bus_wdata,
    output logic [DW-1:0]    bus_rdata,
    output logic             irq
);
    localparam int unsigned NB = DW / 8;

    logic [NB-1:0] cnt_we;
    logic          ctl_we;
    logic          tick;
    logic [DW-1:0] count_v;
    logic [DW-1:0] stamp_v;
    ctrl_t         ctrl_v;

    evt_reg_dec #(.DW(DW)) dec_i (
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_be   (bus_be),
        .count    (count_v),
        .stamp    (stamp_v),
        .ctrl     (ctrl_v),
        .cnt_we   (cnt_we),
        .ctl_we   (ctl_we),
        .rdata    (bus_rdata)
    );

    evt_tick_gen #(.PRESCALE(PRESCALE)) tick_i (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (ctrl_v.run),
        .tick  (tick)
    );

    evt_stamp_ctr #(.DW(DW)) stamp_i (
        .clk   (clk),
        .rst_n (rst_n),
        .stamp (stamp_v)
    );

    evt_countdown #(.DW(DW)) cd_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .cnt_we (cnt_we),
        .ctl_we (ctl_we),
        .wdata  (bus_wdata),
        .count  (count_v),
        .ctrl   (ctrl_v)
    );

    // Interrupt: a level that follows the sticky expiry flag.
    assign irq = ctrl_v.expd;
endmodule

// File: rtl/evt_timer_chk.sv
// Checker for the event timer, bound to the top module. It relates the bus
// ports, the irq output and the countdown state over time.
module evt_timer_chk
    import evt_timer_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_sel,
    input logic             bus_wr,
    input logic [4:0]       bus_addr,
    input logic [DW/8-1:0]  bus_be,
    input logic [DW-1:0]    bus_wdata,
    input logic             irq,
    input logic [DW-1:0]    count,
    input logic [DW-1:0]    stamp,
    input logic [3:0]       ctrl
);
    logic cnt_wr, ctl_wr, run;

    assign cnt_wr = bus_sel && bus_wr && (bus_addr == OFS_COUNT) && (|bus_be);
    assign ctl_wr = bus_sel && bus_wr && (bus_addr == OFS_CTRL) && bus_be[0];
    assign run    = ctrl[0];

    // R2: the timestamp advances by one every clock
    a_r2_stamp_step: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> stamp == $past(stamp) + 1'b1);

    // R4: while running, the count steps down by at most one
    a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(run) && !$past(cnt_wr))
        |-> (count == $past(count) || count == $past(count) - 1'b1));

    // R8: while stopped, the count holds
    a_r8_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(run) && !$past(cnt_wr)) |-> count == $past(count));

    // R5: a new expiry leaves the count at zero and the timer stopped
    a_r5_expiry_stops: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $rose(irq) && !$past(cnt_wr) && !$past(ctl_wr))
        |-> (count == '0 && !run));

    // R6: the interrupt only rises out of a running countdown
    a_r6_irq_from_run: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $rose(irq)) |-> $past(run));

    // R9: the interrupt stays up until a flag-clearing write
    a_r9_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(irq) && !$past(ctl_wr && bus_wdata[BIT_EXP])) |-> irq);
endmodule

bind evt_timer evt_timer_chk #(.DW(DW)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_be    (bus_be),
    .bus_wdata (bus_wdata),
    .irq       (irq),
    .count     (count_v),
    .stamp     (stamp_v),
    .ctrl      (ctrl_v)
);

// File: tb/evt_timer_tb_top.sv
// Bench for the event timer: a vector table of one-shot runs, then directed
// tests for reset, byte lanes, stop, flag handling and the expiry/clear race.
module evt_timer_tb_top;
    localparam int unsigned P = 4;

    localparam int NV = 4;
    localparam logic [31:0] VEC_CNT [NV] = '{32'd15, 32'd1, 32'd3, 32'd40};
    localparam logic [7:0]  VEC_CTL [NV] = '{8'h01, 8'h03, 8'h05, 8'h07};
    localparam logic [7:0]  VEC_EXP [NV] = '{8'h80, 8'h82, 8'h84, 8'h86};

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_sel, bus_wr;
    logic [4:0]  bus_addr;
    logic [3:0]  bus_be;
    logic [31:0] bus_wdata, bus_rdata;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    evt_timer #(.DW(32), .PRESCALE(P)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_be    (bus_be),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive a write now; it lands on the next rising edge. Returns at the next falling edge.
    task automatic wr(input logic [4:0] a, input logic [3:0] be, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_be = '0;
    endtask

    // Combinational read in the low phase, consumes no edge.
    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v, s1, s2;
        rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
        bus_addr = '0; bus_be = '0; bus_wdata = '0;
        repeat (3) @(negedge clk);

        // R1 reset state
        rd(5'h00, v); check("R1 count", v, 0);
        rd(5'h08, v); check("R1 stamp", v, 0);
        rd(5'h14, v); check("R1 ctrl", v, 0);
        check("R1 irq", {31'b0, irq}, 0);
        rst_n = 1'b1;

        // R2 timestamp rate and write ignore
        rd(5'h08, s1);
        repeat (5) @(negedge clk);
        rd(5'h08, s2); check("R2 step", s2, s1 + 5);
        wr(5'h08, 4'hF, 32'h0);
        rd(5'h08, v); check("R2 write ignored", v, s2 + 1);

        // R11 lane-0 gating and unmapped reads
        wr(5'h14, 4'b1110, 32'h0000_0001);
        rd(5'h14, v); check("R11 ctrl no lane0", v, 0);
        rd(5'h04, v); check("R11 unmapped 04", v, 0);
        rd(5'h10, v); check("R11 unmapped 10", v, 0);

        // R3 byte lanes
        wr(5'h00, 4'hF, 32'h1122_3344);
        wr(5'h00, 4'b0100, 32'h00AA_0000);
        rd(5'h00, v); check("R3 lane merge", v, 32'h11AA_3344);

        // R4 full-scale load and first decrement timing
        wr(5'h00, 4'hF, 32'hFFFF_FFFF);
        rd(5'h00, v); check("R4 load max", v, 32'hFFFF_FFFF);
        wr(5'h14, 4'h1, 32'h01);
        repeat (P - 1) @(negedge clk);
        rd(5'h00, v); check("R4 before first tick", v, 32'hFFFF_FFFF);
        @(negedge clk);
        rd(5'h00, v); check("R4 first tick", v, 32'hFFFF_FFFE);
        wr(5'h14, 4'h1, 32'h00);
        rd(5'h00, v); check("R4 stopped value", v, 32'hFFFF_FFFE);

        // R5 R6 R10 R7 vector table of one-shot runs
        for (int i = 0; i < NV; i++) begin
            wr(5'h00, 4'hF, VEC_CNT[i]);
            wr(5'h14, 4'h1, {24'h0, VEC_CTL[i]});
            repeat (VEC_CNT[i] * P - 1) @(negedge clk);
            rd(5'h00, v); check("R5 count one before expiry", v, 1);
            check("R6 irq low before expiry", {31'b0, irq}, 0);
            @(negedge clk);
            check("R6 irq at expiry", {31'b0, irq}, 1);
            rd(5'h00, v); check("R5 count zero", v, 0);
            rd(5'h14, v); check("R10 ctrl after expiry", v, {24'h0, VEC_EXP[i]});
            repeat (2 * P) @(negedge clk);
            rd(5'h00, v); check("R5 count held at zero", v, 0);
            wr(5'h14, 4'h1, 32'h80);
            check("R7 irq cleared", {31'b0, irq}, 0);
        end

        // R8 stop mid-run and restart
        wr(5'h00, 4'hF, 32'd20);
        wr(5'h14, 4'h1, 32'h01);
        repeat (2 * P - 1) @(negedge clk);
        wr(5'h14, 4'h1, 32'h00);
        rd(5'h00, v); check("R8 stop value", v, 32'd18);
        repeat (3 * P) @(negedge clk);
        rd(5'h00, v); check("R8 count holds", v, 32'd18);
        check("R8 no irq while stopped", {31'b0, irq}, 0);
        wr(5'h14, 4'h1, 32'h01);
        repeat (18 * P - 1) @(negedge clk);
        check("R8 restart not yet expired", {31'b0, irq}, 0);
        @(negedge clk);
        check("R8 restart expiry", {31'b0, irq}, 1);

        // R7 write without bit 7 keeps the flag
        wr(5'h14, 4'h1, 32'h02);
        rd(5'h14, v); check("R7 flag kept", v, 32'h82);
        wr(5'h14, 4'h1, 32'h80);
        rd(5'h14, v); check("R7 flag cleared", v, 32'h00);

        // R9 expiry and clear on the same edge
        wr(5'h00, 4'hF, 32'd5);
        wr(5'h14, 4'h1, 32'h01);
        repeat (5 * P - 1) @(negedge clk);
        wr(5'h14, 4'h1, 32'h80);
        check("R9 irq survives clear", {31'b0, irq}, 1);
        rd(5'h14, v); check("R9 ctrl", v, 32'h80);
        wr(5'h14, 4'h1, 32'h80);
        check("R9 later clear", {31'b0, irq}, 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule